// File: doc/BRIEF.md
# Indirect Control/Status Register Port for a Network Controller

This block is the host-visible register file of a packet controller. The host never addresses a control register directly. It writes a register number into an index port and then reads or writes the selected register through a data port. A read of a third port returns the whole block to its reset state. A fourth port is reserved. Its reads return zero and writes to it have no effect.

Register 0 is the main control and status word. It carries three kinds of bits: self-clearing command bits that produce one-cycle pulses toward the controller core, a run state reported through the start and stop bits, and latched event flags raised by the DMA engines. The host clears each event flag by writing a one to it. An interrupt-enable bit gates the interrupt line. The other registers hold the initialisation-block pointer halves, a 64-bit multicast filter, a mode word, a read-only chip identity word and a saturating missed-frame counter. Their values are driven out to the controller core.

Host ports are decoded at offsets 0x10 (data), 0x12 (index), 0x14 (reset on read) and 0x16 (reserved). All four are 16 bits wide. Host reads are combinational from the selected register. Writes and read side effects take place at the clock edge.

Top module: `lan_csr_port`

## Requirements
- R1: After rst_n low, or after any host read of offset 0x14, register 0 reads 0x0004, the index port reads 0, and registers 1, 2, 8 to 11, 15 and 112 read 0. All command pulses are low.
- R2: A write to offset 0x12 stores the low IDX_W bits of the data as the register index. Offset 0x12 reads that index back with the upper bits zero. Offset 0x10 reads or writes the register that the index selects.
- R3: Registers 1 and 2 (pointer low/high), 8 to 11 (filter words, register 8 being bits 15:0 of the filter) and 15 (mode) are 16-bit read/write. They drive init_block_addr = {reg2, reg1}, mcast_filter and mode_word.
- R4: The chip identity is (PART_NUM << 12) | 0x003. Register 88 returns bits 15:0 of it and register 89 returns bits 31:16. Writes to 88, 89 and 112 are ignored. Every other undefined index reads 0 and ignores writes. Offset 0x16 reads 0 and ignores writes.
- R5: Each event input pulse sets its flag in register 0: init-done bit 8, transmit bit 9, receive bit 10, memory error bit 11, missed frame bit 12, babble bit 14. A flag stays set until the host writes a 1 to that bit of register 0. Writing 0 leaves a flag unchanged. An event that arrives in the same cycle as its clear leaves the flag set.
- R6: Bit 15 of register 0 reads the OR of bits 11, 12 and 14 and ignores writes. Bits 0, 3, 4, 5, 7 and 13 read 0.
- R7: Bit 6 (interrupt enable) takes the written value on every register-0 write that does not carry the stop bit. irq is high exactly when bit 6 is set and any of bits 8, 9, 10 or 15 is set.
- R8: Writing bit 0 (init) while not running gives a one-cycle cmd_init in the cycle after the write and leaves the block idle, so bits 2 and 1 read 0. Writing bit 1 (start) while not running gives cmd_start and enters running, where bit 1 reads 1 and bit 2 reads 0. Init and start in the same write end in running. While running, init and start are ignored.
- R9: A register-0 write with bit 2 (stop) set gives cmd_stop in any state. Afterwards bit 2 reads 1, and bits 1 and 6 read 0. Every other command bit in that write is ignored.
- R10: Bit 3 (transmit demand) gives a one-cycle cmd_tx_demand only when the block was already running before the write.
- R11: Register 112 counts the cycles in which ev_missed is high. It saturates at 2^MISS_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_ofs | input | 5 | Host port offset (0x10 data, 0x12 index, 0x14 reset, 0x16 reserved) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (only side effect: reset port) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational |
| ev_init_done | input | 1 | Initialisation complete event |
| ev_tx_done | input | 1 | Transmit complete event |
| ev_rx_done | input | 1 | Receive complete event |
| ev_mem_err | input | 1 | Memory/arbitration error event |
| ev_missed | input | 1 | Missed frame event |
| ev_babble | input | 1 | Transmit babble event |
| cmd_init | output | 1 | Init command pulse |
| cmd_start | output | 1 | Start command pulse |
| cmd_stop | output | 1 | Stop command pulse |
| cmd_tx_demand | output | 1 | Transmit demand pulse |
| irq | output | 1 | Interrupt request |
| init_block_addr | output | 32 | Init-block pointer {reg2, reg1} |
| mode_word | output | 16 | Mode register value |
| mcast_filter | output | 64 | Multicast filter, register 8 in the low word |

## Verification
The assertions assume that host_wr and host_rd are never high in the same cycle. They also assume that the event inputs are single-cycle or level indications that need no handshake. The bench keeps to both: each access task raises one strobe for exactly one clock, and events are driven only between accesses, except in the one case that deliberately overlaps an event with its clear. The command sweep drives all sixteen command nibbles from each of the three run states. The event sweep applies all 64 event combinations with the interrupt enable both off and on. A full index sweep checks every register number against an arithmetic model.

// File: rtl/lcsr_pkg.sv
// Package: shared constants for the indirect register port.
// Assumes host offsets are 5 bits and every register is 16 bits wide.
package lcsr_pkg;
    localparam int DATA_W = 16;
    localparam int OFS_W  = 5;

    // host port offsets (decoded by the bus side)
    localparam logic [OFS_W-1:0] OFS_DATA  = 5'h10;
    localparam logic [OFS_W-1:0] OFS_INDEX = 5'h12;
    localparam logic [OFS_W-1:0] OFS_RESET = 5'h14;
    localparam logic [OFS_W-1:0] OFS_BUSIF = 5'h16;

    // register 0 bit positions (software depends on them)
    localparam int B_INIT = 0;
    localparam int B_STRT = 1;
    localparam int B_STOP = 2;
    localparam int B_TDMD = 3;
    localparam int B_IE   = 6;
    localparam int B_IDON = 8;
    localparam int B_TINT = 9;
    localparam int B_RINT = 10;
    localparam int B_MERR = 11;
    localparam int B_MISS = 12;
    localparam int B_BABL = 14;
    localparam int B_ERR  = 15;

    // mask of write-one-to-clear event flags
    localparam logic [DATA_W-1:0] EV_MASK = 16'h5F00;

    // register indices
    localparam int IDX_PTR_LO  = 1;
    localparam int IDX_PTR_HI  = 2;
    localparam int IDX_FILT0   = 8;
    localparam int IDX_MODE    = 15;
    localparam int IDX_ID_LO   = 88;
    localparam int IDX_ID_HI   = 89;
    localparam int IDX_MISSCNT = 112;

    typedef enum logic [1:0] {
        RUN_STOPPED = 2'd0,
        RUN_IDLE    = 2'd1,
        RUN_ACTIVE  = 2'd2
    } run_state_e;
endpackage

// File: rtl/lcsr_port_decode.sv
// Module: host port decoder and index register.
// Holds the register index, produces the data-port write strobe and the
// reset-port request, and muxes host read data. Assumes host_wr and host_rd
// are never high together.
module lcsr_port_decode
    import lcsr_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,        // core reset, already merged with reset_req
    input  logic [OFS_W-1:0]  host_ofs,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] status_rdata,
    input  logic [DATA_W-1:0] aux_rdata,
    output logic [IDX_W-1:0]  idx,
    output logic              data_wr,
    output logic              reset_req,
    output logic [DATA_W-1:0] host_rdata
);
    localparam int PAD_W = DATA_W - IDX_W;

    logic [IDX_W-1:0] idx_q;

    // strobe decode from the host offset
    always_comb begin
        data_wr   = host_wr && (host_ofs == OFS_DATA);
        reset_req = host_rd && (host_ofs == OFS_RESET);
    end

    // index register: loaded by writes to the index port
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (host_wr && (host_ofs == OFS_INDEX))
            idx_q <= host_wdata[IDX_W-1:0];
    end

    assign idx = idx_q;

    // read mux: data port follows the index, reserved and reset ports read zero
    always_comb begin
        host_rdata = '0;
        if (host_ofs == OFS_DATA)
            host_rdata = (idx_q == '0) ? status_rdata : aux_rdata;
        else if (host_ofs == OFS_INDEX)
            host_rdata = {{PAD_W{1'b0}}, idx_q};
    end

    // R2: the index changes only through an index-port write
    p_index_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && (host_ofs == OFS_INDEX)) |=> $stable(idx_q));
endmodule

// File: rtl/lcsr_status.sv
// Module: register 0, the control/status word.
// Runs the stopped/idle/running state, emits one-cycle command pulses,
// latches event flags (write one to clear, a new event beats its clear),
// forms the error summary and the interrupt line. Assumes wr is one cycle
// per host write.
module lcsr_status
    import lcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ev_init_done,
    input  logic              ev_tx_done,
    input  logic              ev_rx_done,
    input  logic              ev_mem_err,
    input  logic              ev_missed,
    input  logic              ev_babble,
    output logic [DATA_W-1:0] status_word,
    output logic              cmd_init,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_tx_demand,
    output logic              irq
);
    run_state_e        state_q;
    logic              ie_q;
    logic [DATA_W-1:0] ev_q;
    logic [DATA_W-1:0] ev_set;
    logic [DATA_W-1:0] ev_clr;
    logic              err_sum;
    logic              may_launch;

    // place event inputs at their flag positions
    always_comb begin
        ev_set          = '0;
        ev_set[B_IDON]  = ev_init_done;
        ev_set[B_TINT]  = ev_tx_done;
        ev_set[B_RINT]  = ev_rx_done;
        ev_set[B_MERR]  = ev_mem_err;
        ev_set[B_MISS]  = ev_missed;
        ev_set[B_BABL]  = ev_babble;
        ev_clr          = wr ? (wdata & EV_MASK) : '0;
        may_launch      = (state_q != RUN_ACTIVE);
    end

    // event flags: clear on written ones, set by events, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            ev_q <= '0;
        else
            ev_q <= ((ev_q & ~ev_clr) | ev_set) & EV_MASK;
    end

    // run state, interrupt enable and command pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= RUN_STOPPED;
            ie_q          <= 1'b0;
            cmd_init      <= 1'b0;
            cmd_start     <= 1'b0;
            cmd_stop      <= 1'b0;
            cmd_tx_demand <= 1'b0;
        end else begin
            cmd_init      <= 1'b0;
            cmd_start     <= 1'b0;
            cmd_stop      <= 1'b0;
            cmd_tx_demand <= 1'b0;
            if (wr) begin
                if (wdata[B_STOP]) begin
                    state_q  <= RUN_STOPPED;
                    ie_q     <= 1'b0;
                    cmd_stop <= 1'b1;
                end else begin
                    ie_q <= wdata[B_IE];
                    if (wdata[B_INIT] && may_launch) begin
                        cmd_init <= 1'b1;
                        state_q  <= RUN_IDLE;
                    end
                    if (wdata[B_STRT] && may_launch) begin
                        cmd_start <= 1'b1;
                        state_q   <= RUN_ACTIVE;
                    end
                    if (wdata[B_TDMD] && (state_q == RUN_ACTIVE))
                        cmd_tx_demand <= 1'b1;
                end
            end
        end
    end

    // readable word and interrupt line
    always_comb begin
        err_sum             = ev_q[B_MERR] | ev_q[B_MISS] | ev_q[B_BABL];
        status_word         = ev_q;
        status_word[B_ERR]  = err_sum;
        status_word[B_IE]   = ie_q;
        status_word[B_STOP] = (state_q == RUN_STOPPED);
        status_word[B_STRT] = (state_q == RUN_ACTIVE);
        irq = ie_q & (ev_q[B_IDON] | ev_q[B_TINT] | ev_q[B_RINT] | err_sum);
    end

    // R9: a stop write leaves the block stopped with interrupts disabled
    p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[B_STOP]) |=> (cmd_stop && status_word[B_STOP]
                                   && !status_word[B_STRT] && !status_word[B_IE]
                                   && !cmd_init && !cmd_start && !cmd_tx_demand));

    // R8: a start pulse only follows a non-running state
    p_start_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> ($past(state_q) != RUN_ACTIVE));

    // R10: transmit demand only follows the running state
    p_tdmd_running_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_tx_demand |-> ($past(state_q) == RUN_ACTIVE));

    // R5: a latched receive flag survives any cycle without a host write
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && status_word[B_RINT]) |=> status_word[B_RINT]);

    // R7: a receive event with interrupts kept enabled raises irq
    p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_done && ie_q && !(wr && (wdata[B_STOP] || !wdata[B_IE]))) |=> irq);
endmodule

// File: rtl/lcsr_aux_regs.sv
// Module: registers other than register 0.
// Pointer halves, multicast filter words, mode word, read-only identity and
// a saturating missed-frame counter. Assumes MISS_W <= 16 and that the
// filter indices stay below the mode index.
module lcsr_aux_regs
    import lcsr_pkg::*;
#(
    parameter int          IDX_W      = 7,
    parameter int          MISS_W     = 16,
    parameter int          FILT_WORDS = 4,
    parameter logic [15:0] PART_NUM   = 16'h5A3C
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [IDX_W-1:0]             idx,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         ev_missed,
    output logic [DATA_W-1:0]            rdata,
    output logic [2*DATA_W-1:0]          init_block_addr,
    output logic [DATA_W-1:0]            mode_word,
    output logic [FILT_WORDS*DATA_W-1:0] mcast_filter
);
    localparam logic [31:0]       CHIP_ID  = {4'h0, PART_NUM, 12'h003};
    localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

    logic [DATA_W-1:0] ptr_lo_q;
    logic [DATA_W-1:0] ptr_hi_q;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] filt_q [FILT_WORDS];
    logic [MISS_W-1:0] miss_q;

    // pointer halves and mode word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_lo_q <= '0;
            ptr_hi_q <= '0;
            mode_q   <= '0;
        end else if (wr) begin
            if (idx == IDX_W'(IDX_PTR_LO)) ptr_lo_q <= wdata;
            if (idx == IDX_W'(IDX_PTR_HI)) ptr_hi_q <= wdata;
            if (idx == IDX_W'(IDX_MODE))   mode_q   <= wdata;
        end
    end

    // one storage word per filter register
    for (genvar g = 0; g < FILT_WORDS; g++) begin : g_filt
        always_ff @(posedge clk) begin
            if (!rst_n)
                filt_q[g] <= '0;
            else if (wr && (idx == IDX_W'(IDX_FILT0 + g)))
                filt_q[g] <= wdata;
        end
        assign mcast_filter[g*DATA_W +: DATA_W] = filt_q[g];
    end

    // missed-frame counter, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            miss_q <= '0;
        else if (ev_missed && (miss_q != MISS_MAX))
            miss_q <= miss_q + 1'b1;
    end

    // read mux over the index
    always_comb begin
        rdata = '0;
        if (idx == IDX_W'(IDX_PTR_LO))  rdata = ptr_lo_q;
        if (idx == IDX_W'(IDX_PTR_HI))  rdata = ptr_hi_q;
        if (idx == IDX_W'(IDX_MODE))    rdata = mode_q;
        if (idx == IDX_W'(IDX_ID_LO))   rdata = CHIP_ID[15:0];
        if (idx == IDX_W'(IDX_ID_HI))   rdata = CHIP_ID[31:16];
        if (idx == IDX_W'(IDX_MISSCNT)) rdata[MISS_W-1:0] = miss_q;
        for (int i = 0; i < FILT_WORDS; i++)
            if (idx == IDX_W'(IDX_FILT0 + i)) rdata = filt_q[i];
    end

    assign init_block_addr = {ptr_hi_q, ptr_lo_q};
    assign mode_word       = mode_q;

    // R11: the count moves only on a missed-frame event
    p_miss_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_missed |=> $stable(miss_q));

    // R11: once full, the count stays full
    p_miss_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_q == MISS_MAX) |=> (miss_q == MISS_MAX));

    // R3: the pointer is unchanged without a data write
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(init_block_addr));
endmodule

// File: rtl/lan_csr_port.sv
// Module: top of the indirect register port.
// Joins the port decoder, register 0 and the auxiliary registers. A read of
// the reset port acts as a synchronous reset of every register.
module lan_csr_port
    import lcsr_pkg::*;
#(
    parameter int          IDX_W      = 7,
    parameter int          MISS_W     = 16,
    parameter int          FILT_WORDS = 4,
    parameter logic [15:0] PART_NUM   = 16'h5A3C
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [4:0]                   host_ofs,
    input  logic                         host_wr,
    input  logic                         host_rd,
    input  logic [15:0]                  host_wdata,
    output logic [15:0]                  host_rdata,
    input  logic                         ev_init_done,
    input  logic                         ev_tx_done,
    input  logic                         ev_rx_done,
    input  logic                         ev_mem_err,
    input  logic                         ev_missed,
    input  logic                         ev_babble,
    output logic                         cmd_init,
    output logic                         cmd_start,
    output logic                         cmd_stop,
    output logic                         cmd_tx_demand,
    output logic                         irq,
    output logic [31:0]                  init_block_addr,
    output logic [15:0]                  mode_word,
    output logic [FILT_WORDS*16-1:0]     mcast_filter
);
    logic [IDX_W-1:0]  idx;
    logic              data_wr;
    logic              reset_req;
    logic              core_rst_n;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] aux_rdata;
    logic              status_wr;
    logic              aux_wr;

    // merged reset and per-target write strobes
    always_comb begin
        core_rst_n = rst_n && !reset_req;
        status_wr  = data_wr && (idx == '0);
        aux_wr     = data_wr && (idx != '0);
    end

    lcsr_port_decode #(.IDX_W(IDX_W)) u_decode (
        .clk          (clk),
        .rst_n        (core_rst_n),
        .host_ofs     (host_ofs),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .host_wdata   (host_wdata),
        .status_rdata (status_word),
        .aux_rdata    (aux_rdata),
        .idx          (idx),
        .data_wr      (data_wr),
        .reset_req    (reset_req),
        .host_rdata   (host_rdata)
    );

    lcsr_status u_status (
        .clk           (clk),
        .rst_n         (core_rst_n),
        .wr            (status_wr),
        .wdata         (host_wdata),
        .ev_init_done  (ev_init_done),
        .ev_tx_done    (ev_tx_done),
        .ev_rx_done    (ev_rx_done),
        .ev_mem_err    (ev_mem_err),
        .ev_missed     (ev_missed),
        .ev_babble     (ev_babble),
        .status_word   (status_word),
        .cmd_init      (cmd_init),
        .cmd_start     (cmd_start),
        .cmd_stop      (cmd_stop),
        .cmd_tx_demand (cmd_tx_demand),
        .irq           (irq)
    );

    lcsr_aux_regs #(
        .IDX_W      (IDX_W),
        .MISS_W     (MISS_W),
        .FILT_WORDS (FILT_WORDS),
        .PART_NUM   (PART_NUM)
    ) u_aux (
        .clk             (clk),
        .rst_n           (core_rst_n),
        .wr              (aux_wr),
        .idx             (idx),
        .wdata           (host_wdata),
        .ev_missed       (ev_missed),
        .rdata           (aux_rdata),
        .init_block_addr (init_block_addr),
        .mode_word       (mode_word),
        .mcast_filter    (mcast_filter)
    );

    // R1: after a reset-port read the block comes up stopped and quiet
    p_soft_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (host_ofs == OFS_RESET)) |=> (status_word == 16'h0004
            && idx == '0 && !cmd_init && !cmd_start && !cmd_stop && !cmd_tx_demand));
endmodule

// File: tb/lan_csr_port_tb_top.sv
// Bench: sweeps indices, command nibbles per run state and event combinations.
module lan_csr_port_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] PART       = 16'h5A3C;
    localparam logic [31:0] CHIP_ID    = {4'h0, PART, 12'h003};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  host_ofs = 5'h0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic [5:0]  ev = 6'h0;   // {babble, missed, mem_err, rx, tx, init_done}
    logic        cmd_init, cmd_start, cmd_stop, cmd_tx_demand, irq;
    logic [31:0] init_block_addr;
    logic [15:0] mode_word;
    logic [63:0] mcast_filter;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lan_csr_port #(.IDX_W(7), .MISS_W(4), .FILT_WORDS(4), .PART_NUM(PART)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_ofs(host_ofs), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ev_init_done(ev[0]), .ev_tx_done(ev[1]), .ev_rx_done(ev[2]),
        .ev_mem_err(ev[3]), .ev_missed(ev[4]), .ev_babble(ev[5]),
        .cmd_init(cmd_init), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_tx_demand(cmd_tx_demand), .irq(irq),
        .init_block_addr(init_block_addr), .mode_word(mode_word),
        .mcast_filter(mcast_filter)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] ofs, input logic [15:0] d);
        @(negedge clk);
        host_ofs = ofs; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] ofs, output logic [15:0] d);
        @(negedge clk);
        host_ofs = ofs; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic reg_read(input int i, output logic [15:0] d);
        bus_write(5'h12, 16'(i));
        bus_read(5'h10, d);
    endtask

    task automatic reg_write(input int i, input logic [15:0] d);
        bus_write(5'h12, 16'(i));
        bus_write(5'h10, d);
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'(i * 16'h0101) ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] ev_bits(input logic [5:0] v);
        return {v[3] | v[4] | v[5], v[5], 1'b0, v[4], v[3], v[2], v[1], v[0], 8'h00};
    endfunction

    function automatic logic [15:0] exp_reg(input int i);
        if (i == 0) return 16'h0004;
        if (i == 1 || i == 2 || i == 15 || (i >= 8 && i <= 11)) return pat(i);
        if (i == 88) return CHIP_ID[15:0];
        if (i == 89) return CHIP_ID[31:16];
        return 16'h0000;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: hard reset state
        bus_read(5'h10, d); chk("R1 reg0 after reset", 64'(d), 64'h0004);
        bus_read(5'h12, d); chk("R1 index after reset", 64'(d), 64'h0);
        chk("R1 pulses after reset", 64'({cmd_init, cmd_start, cmd_stop, cmd_tx_demand}), 64'h0);

        // R2/R3/R4: write a pattern to every nonzero index, then read all back
        for (int i = 1; i < 128; i++) reg_write(i, pat(i));
        for (int i = 0; i < 128; i++) begin
            bus_write(5'h12, 16'(i | 16'hFF80));
            bus_read(5'h12, d);  chk("R2 index readback", 64'(d), 64'(i));
            bus_read(5'h10, d);  chk("R3 R4 register sweep", 64'(d), 64'(exp_reg(i)));
        end
        chk("R3 pointer output", 64'(init_block_addr), 64'({pat(2), pat(1)}));
        chk("R3 mode output", 64'(mode_word), 64'(pat(15)));
        chk("R3 filter output", mcast_filter, {pat(11), pat(10), pat(9), pat(8)});
        bus_write(5'h16, 16'hFFFF);
        bus_read(5'h16, d); chk("R4 reserved port reads zero", 64'(d), 64'h0);
        reg_read(15, d); chk("R4 reserved write no effect", 64'(d), 64'(pat(15)));

        // R1: soft reset through the reset port
        bus_read(5'h14, d);
        bus_read(5'h12, d); chk("R1 index after soft reset", 64'(d), 64'h0);
        bus_read(5'h10, d); chk("R1 reg0 after soft reset", 64'(d), 64'h0004);
        chk("R1 outputs after soft reset", {init_block_addr, mode_word, mcast_filter[15:0]}, 64'h0);
        reg_read(8, d); chk("R1 filter after soft reset", 64'(d), 64'h0);

        // R8/R9/R10: all command nibbles from each run state
        for (int st = 0; st < 3; st++) begin
            for (int c = 0; c < 16; c++) begin
                logic [3:0] exp_p;
                int ns;
                bit can;
                bus_read(5'h14, d);
                if (st == 1) bus_write(5'h10, 16'h0001);
                if (st == 2) bus_write(5'h10, 16'h0002);
                bus_write(5'h10, 16'(c) | 16'h0040);
                can = (st != 2);
                if (c[2]) begin
                    exp_p = 4'b0010; ns = 0;
                end else begin
                    exp_p = {c[0] & can, c[1] & can, 1'b0, c[3] & (st == 2)};
                    ns = (c[1] && can) ? 2 : ((c[0] && can) ? 1 : st);
                end
                chk("R8 R9 R10 command pulses",
                    64'({cmd_init, cmd_start, cmd_stop, cmd_tx_demand}), 64'(exp_p));
                @(negedge clk);
                chk("R8 pulses last one cycle",
                    64'({cmd_init, cmd_start, cmd_stop, cmd_tx_demand}), 64'h0);
                bus_read(5'h10, d);
                chk("R8 R9 run state and enable", 64'(d),
                    64'((ns == 0 ? 16'h0004 : 16'h0) | (ns == 2 ? 16'h0002 : 16'h0)
                        | (c[2] ? 16'h0 : 16'h0040)));
            end
        end

        // R5/R6/R7: all event combinations with enable off and on
        for (int ie = 0; ie < 2; ie++) begin
            for (int v = 0; v < 64; v++) begin
                logic [15:0] ie_w;
                ie_w = (ie != 0) ? 16'h0040 : 16'h0000;
                bus_read(5'h14, d);
                bus_write(5'h10, ie_w);
                @(negedge clk); ev = 6'(v);
                @(negedge clk); ev = 6'h0;
                chk("R7 irq after events", 64'(irq), 64'((ie != 0) && (v != 0)));
                bus_read(5'h10, d);
                chk("R5 R6 flags latched", 64'(d), 64'(16'h0004 | ie_w | ev_bits(6'(v))));
                bus_write(5'h10, ev_bits(6'(v)) | ie_w);
                bus_read(5'h10, d);
                chk("R5 flags cleared by ones", 64'(d), 64'(16'h0004 | ie_w));
                chk("R7 irq after clear", 64'(irq), 64'h0);
            end
        end

        // R5: event beats its clear in the same cycle, and a zero write keeps flags
        bus_read(5'h14, d);
        @(negedge clk);
        host_ofs = 5'h10; host_wdata = 16'h0400; host_wr = 1'b1; ev = 6'b000100;
        @(negedge clk);
        host_wr = 1'b0; ev = 6'h0;
        bus_read(5'h10, d); chk("R5 set wins over clear", 64'(d), 64'h0404);
        bus_write(5'h10, 16'h0000);
        bus_read(5'h10, d); chk("R5 zero write keeps flag", 64'(d), 64'h0404);
        bus_write(5'h10, 16'hA0B0);
        bus_read(5'h10, d); chk("R6 reserved bits read zero", 64'(d), 64'h0404);

        // R11: missed-frame counting and saturation
        bus_read(5'h14, d);
        @(negedge clk); ev = 6'b010000;
        repeat (5) @(negedge clk);
        ev = 6'h0;
        reg_read(112, d); chk("R11 count of five", 64'(d), 64'h5);
        bus_write(5'h10, 16'h0009);
        bus_read(5'h10, d); chk("R11 count read only", 64'(d), 64'h5);
        @(negedge clk); ev = 6'b010000;
        repeat (20) @(negedge clk);
        ev = 6'h0;
        bus_read(5'h10, d); chk("R11 count saturates", 64'(d), 64'hF);
        bus_write(5'h12, 16'h0000);
        bus_read(5'h10, d); chk("R6 error summary from missed", 64'(d), 64'h9004);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule